// File: doc/BRIEF.md
# Instruction Push Address Router

This block sits between the store ports of five processor cores and three per-thread instruction queues. One control core, three thread cores and one network core can each present a 32-bit store with an address. A store that lands on one of three fixed push addresses becomes a single instruction push into one thread queue. The store data is passed through unchanged as the instruction word.

Which queue receives the push depends on both the address and the core that issued the store. The control core picks a thread through the address. Each thread core may only use the lowest push address, and its push always goes to its own thread. A thread core that stores to either of the other two push addresses is stalled permanently until reset. The network core has no push path, so its stores are not routed at all.

Back-pressure is passed straight through. If the target queue reports full, or another core wins the same queue in that cycle, the issuing core is stalled. It holds its store until the push is accepted.

Top module: `push_router`

## Requirements
- R1: A control core (index 0) store to 0xFFE40000, 0xFFE50000 or 0xFFE60000 pushes its data to thread 0, 1 or 2 in the same cycle. The core is not stalled when that queue has space.
- R2: A store to 0xFFE40000 from thread core n (core index n+1, n = 0..2) pushes its data to thread n in the same cycle.
- R3: A store from a thread core to 0xFFE50000 or 0xFFE60000 makes no push and stalls that core in the same cycle. From the next cycle the core's stall and hang flag stay high until reset, and later stores from that core produce no push.
- R4: A store from the network core (index 4) to any push address makes no push and never stalls that core.
- R5: While the target queue's full input is high, no push is made to it and the issuing core is stalled. The push happens in the first cycle the full input is low.
- R6: When several cores target the same queue in one cycle, the lowest core index wins, so the control core comes first. Each losing core is stalled and its data is not pushed.
- R7: A store to an address outside the three push addresses, or no store at all, makes no push and no stall.
- R8: Each accepted store cycle produces exactly one push, on exactly one thread.
- R9: During and right after reset, no push, stall or hang flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| storeValid | input | 5 | Store strobe per core (0 control, 1..3 thread cores, 4 network) |
| storeAddr | input | 5x32 | Store address per core |
| storeData | input | 5x32 | Store data per core |
| queueFull | input | 3 | Full indication from each thread queue |
| pushValid | output | 3 | Push strobe per thread queue |
| pushData | output | 3x32 | Instruction word per thread queue |
| coreStall | output | 5 | Stall back to each core |
| hangErr | output | 5 | Sticky flag: core is hung by an illegal push address |

## Verification
Routing and arbitration are combinational, so a wrong grant shows at the ports in the cycle of the store. It appears as a push on the wrong thread, the wrong core's data, or a stall missing or present where it should not be. The only internal state is the per-core hang register. If it is wrongly set, the stall and flag show from the cycle after the offending store and persist. If it is wrongly cleared, the stall drops while the core is supposed to stay stopped, and a later legal store pushes when it must not.

// File: rtl/push_router_pkg.sv
package push_router_pkg;
  localparam int CORE_COUNT   = 5;
  localparam int THREAD_COUNT = 3;
  localparam int CORE_CTRL    = 0;
  localparam int CORE_NET     = 4;
  localparam int CORE_IDX_W   = $clog2(CORE_COUNT);

  // control -> datapath strobes: which queues push, and from which core
  typedef struct packed {
    logic [THREAD_COUNT-1:0]                 pushEn;
    logic [THREAD_COUNT-1:0][CORE_IDX_W-1:0] srcSel;
  } routeStrobe_t;
endpackage

// File: rtl/push_router_ctrl.sv
module push_router_ctrl
  import push_router_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 32'hFFE40000,
  parameter logic [ADDR_W-1:0] WIN_STRIDE = 32'h00010000
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [CORE_COUNT-1:0]              storeValid,
  input  logic [CORE_COUNT-1:0][ADDR_W-1:0]  storeAddr,
  input  logic [THREAD_COUNT-1:0]            queueFull,
  output routeStrobe_t                       strobe,
  output logic [CORE_COUNT-1:0]              coreStall,
  output logic [CORE_COUNT-1:0]              hangErr
);
  logic [CORE_COUNT-1:0][THREAD_COUNT-1:0] winHit;
  logic [CORE_COUNT-1:0][THREAD_COUNT-1:0] wantQ;
  logic [CORE_COUNT-1:0][THREAD_COUNT-1:0] req;
  logic [CORE_COUNT-1:0][THREAD_COUNT-1:0] grant;
  logic [CORE_COUNT-1:0]                   hangHit;
  logic [CORE_COUNT-1:0]                   hungQ;

  for (genvar c = 0; c < CORE_COUNT; c++) begin : g_core
    for (genvar k = 0; k < THREAD_COUNT; k++) begin : g_win
      assign winHit[c][k] = storeValid[c] &&
        (storeAddr[c] == ADDR_W'(WIN_BASE + ADDR_W'(k) * WIN_STRIDE));
    end

    if (c == CORE_CTRL) begin : g_ctrl
      assign wantQ[c]   = winHit[c];
      assign hangHit[c] = 1'b0;
    end else if (c <= THREAD_COUNT) begin : g_thr
      assign wantQ[c]   = winHit[c][0] ? THREAD_COUNT'(1) << (c - 1) : '0;
      assign hangHit[c] = (|winHit[c][THREAD_COUNT-1:1]) && !hungQ[c];
    end else begin : g_none
      assign wantQ[c]   = '0;
      assign hangHit[c] = 1'b0;
    end

    assign req[c] = wantQ[c] & {THREAD_COUNT{!hungQ[c]}};

    for (genvar t = 0; t < THREAD_COUNT; t++) begin : g_gnt
      assign grant[c][t] = strobe.pushEn[t] && (strobe.srcSel[t] == CORE_IDX_W'(c));
    end

    assign coreStall[c] = hungQ[c] | hangHit[c] | ((|req[c]) & ~(|grant[c]));
  end

  // fixed priority: the lowest core index wins each queue
  always_comb begin
    strobe = '0;
    for (int t = 0; t < THREAD_COUNT; t++) begin
      for (int c = CORE_COUNT - 1; c >= 0; c--) begin
        if (req[c][t]) begin
          strobe.srcSel[t] = CORE_IDX_W'(c);
          strobe.pushEn[t] = !queueFull[t];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) hungQ <= '0;
    else       hungQ <= hungQ | hangHit;
  end

  assign hangErr = hungQ;
endmodule

// File: rtl/push_router_dp.sv
module push_router_dp
  import push_router_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  routeStrobe_t                         strobe,
  input  logic [CORE_COUNT-1:0][DATA_W-1:0]    storeData,
  output logic [THREAD_COUNT-1:0]              pushValid,
  output logic [THREAD_COUNT-1:0][DATA_W-1:0]  pushData
);
  for (genvar t = 0; t < THREAD_COUNT; t++) begin : g_q
    assign pushValid[t] = strobe.pushEn[t];
    assign pushData[t]  = strobe.pushEn[t] ? storeData[strobe.srcSel[t]] : '0;
  end
endmodule

// File: rtl/push_router.sv
module push_router
  import push_router_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 32'hFFE40000,
  parameter logic [ADDR_W-1:0] WIN_STRIDE = 32'h00010000
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [CORE_COUNT-1:0]                storeValid,
  input  logic [CORE_COUNT-1:0][ADDR_W-1:0]    storeAddr,
  input  logic [CORE_COUNT-1:0][DATA_W-1:0]    storeData,
  input  logic [THREAD_COUNT-1:0]              queueFull,
  output logic [THREAD_COUNT-1:0]              pushValid,
  output logic [THREAD_COUNT-1:0][DATA_W-1:0]  pushData,
  output logic [CORE_COUNT-1:0]                coreStall,
  output logic [CORE_COUNT-1:0]                hangErr
);
  routeStrobe_t strobe;

  push_router_ctrl #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_STRIDE(WIN_STRIDE)) ctrl_i (
    .clk(clk), .rstN(rstN), .storeValid(storeValid), .storeAddr(storeAddr),
    .queueFull(queueFull), .strobe(strobe), .coreStall(coreStall), .hangErr(hangErr)
  );

  push_router_dp #(.DATA_W(DATA_W)) dp_i (
    .strobe(strobe), .storeData(storeData), .pushValid(pushValid), .pushData(pushData)
  );
endmodule

// File: rtl/push_router_chk.sv
module push_router_chk
  import push_router_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 32'hFFE40000,
  parameter logic [ADDR_W-1:0] WIN_STRIDE = 32'h00010000
) (
  input logic                                 clk,
  input logic                                 rstN,
  input logic [CORE_COUNT-1:0]                storeValid,
  input logic [CORE_COUNT-1:0][ADDR_W-1:0]    storeAddr,
  input logic [CORE_COUNT-1:0][DATA_W-1:0]    storeData,
  input logic [THREAD_COUNT-1:0]              queueFull,
  input logic [THREAD_COUNT-1:0]              pushValid,
  input logic [THREAD_COUNT-1:0][DATA_W-1:0]  pushData,
  input logic [CORE_COUNT-1:0]                coreStall,
  input logic [CORE_COUNT-1:0]                hangErr
);
  AST_NET_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    !coreStall[CORE_NET]); // R4

  for (genvar t = 0; t < THREAD_COUNT; t++) begin : g_t
    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
      pushValid[t] |-> !queueFull[t]); // R5
    AST_PUSH_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rstN)
      pushValid[t] |-> (|storeValid)); // R7
    AST_CTRL_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
      (storeValid[CORE_CTRL] && !queueFull[t] &&
       storeAddr[CORE_CTRL] == ADDR_W'(WIN_BASE + ADDR_W'(t) * WIN_STRIDE))
      |-> (pushValid[t] && pushData[t] == storeData[CORE_CTRL] && !coreStall[CORE_CTRL])); // R1
  end

  for (genvar c = 1; c <= THREAD_COUNT; c++) begin : g_c
    AST_HANG_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
      (storeValid[c] && storeAddr[c] == ADDR_W'(WIN_BASE + WIN_STRIDE)) |=> hangErr[c]); // R3
    AST_HANG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      hangErr[c] |=> hangErr[c]); // R3
    AST_HANG_STALLS: assert property (@(posedge clk) disable iff (!rstN)
      hangErr[c] |-> coreStall[c]); // R3
  end
endmodule

bind push_router push_router_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_STRIDE(WIN_STRIDE)
) chk_i (
  .clk(clk), .rstN(rstN), .storeValid(storeValid), .storeAddr(storeAddr),
  .storeData(storeData), .queueFull(queueFull), .pushValid(pushValid),
  .pushData(pushData), .coreStall(coreStall), .hangErr(hangErr)
);

// File: tb/push_router_tb_top.sv
module push_router_tb_top;
  import push_router_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] W0 = 32'hFFE40000;
  localparam logic [31:0] W1 = 32'hFFE50000;
  localparam logic [31:0] W2 = 32'hFFE60000;
  localparam logic [31:0] OFF = 32'hFFE40004;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CORE_COUNT-1:0]             storeValid = '0;
  logic [CORE_COUNT-1:0][31:0]       storeAddr = '0;
  logic [CORE_COUNT-1:0][31:0]       storeData = '0;
  logic [THREAD_COUNT-1:0]           queueFull = '0;
  logic [THREAD_COUNT-1:0]           pushValid;
  logic [THREAD_COUNT-1:0][31:0]     pushData;
  logic [CORE_COUNT-1:0]             coreStall;
  logic [CORE_COUNT-1:0]             hangErr;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  push_router dut_i (
    .clk(clk), .rstN(rstN), .storeValid(storeValid), .storeAddr(storeAddr),
    .storeData(storeData), .queueFull(queueFull), .pushValid(pushValid),
    .pushData(pushData), .coreStall(coreStall), .hangErr(hangErr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    storeValid = '0;
    queueFull  = '0;
  endtask

  task automatic put(input int c, input logic [31:0] a, input logic [31:0] d);
    storeValid[c] = 1'b1;
    storeAddr[c]  = a;
    storeData[c]  = d;
  endtask

  task automatic doReset();
    @(negedge clk);
    idle();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic tReset();
    @(negedge clk); #1;
    chk("R9", "push", 32'(pushValid), 0);
    chk("R9", "stall", 32'(coreStall), 0);
    chk("R9", "hang", 32'(hangErr), 0);
  endtask

  task automatic tCtrlRoute();
    logic [31:0] addrs [3] = '{W0, W1, W2};
    for (int t = 0; t < THREAD_COUNT; t++) begin
      @(negedge clk); idle();
      put(0, addrs[t], 32'hA000_0000 + 32'(t));
      #1;
      chk("R1", "pushValid", 32'(pushValid), 32'(1) << t);
      chk("R1", "pushData", pushData[t], 32'hA000_0000 + 32'(t));
      chk("R1", "stall", 32'(coreStall), 0);
      chk("R8", "one push", 32'($countones(pushValid)), 1);
    end
    @(negedge clk); idle();
  endtask

  task automatic tThreadRoute();
    for (int n = 0; n < THREAD_COUNT; n++) begin
      @(negedge clk); idle();
      put(n + 1, W0, 32'h1234_5600 + 32'(n));
      #1;
      chk("R2", "pushValid", 32'(pushValid), 32'(1) << n);
      chk("R2", "pushData", pushData[n], 32'h1234_5600 + 32'(n));
      chk("R2", "stall", 32'(coreStall), 0);
    end
    @(negedge clk); idle();
  endtask

  task automatic tNetwork();
    @(negedge clk); idle();
    put(CORE_NET, W0, 32'hDEAD_0001);
    #1;
    chk("R4", "push W0", 32'(pushValid), 0);
    chk("R4", "stall W0", 32'(coreStall), 0);
    @(negedge clk);
    storeAddr[CORE_NET] = W2;
    #1;
    chk("R4", "push W2", 32'(pushValid), 0);
    chk("R4", "stall W2", 32'(coreStall), 0);
    @(negedge clk); #1;
    chk("R4", "no hang", 32'(hangErr), 0);
    idle();
  endtask

  task automatic tOffWindow();
    @(negedge clk); idle();
    put(0, OFF, 32'h5);
    put(1, 32'h0000_1000, 32'h6);
    put(2, W1 + 32'h8, 32'h7);
    #1;
    chk("R7", "push", 32'(pushValid), 0);
    chk("R7", "stall", 32'(coreStall), 0);
    @(negedge clk); idle(); #1;
    chk("R7", "idle push", 32'(pushValid), 0);
    chk("R7", "idle hang", 32'(hangErr), 0);
  endtask

  task automatic tFull();
    @(negedge clk); idle();
    queueFull = 3'b100;
    put(3, W0, 32'hF00D_0003);
    #1;
    chk("R5", "push while full", 32'(pushValid), 0);
    chk("R5", "stall while full", 32'(coreStall), 32'(1) << 3);
    @(negedge clk); #1;
    chk("R5", "still stalled", 32'(coreStall), 32'(1) << 3);
    @(negedge clk);
    queueFull = '0;
    #1;
    chk("R5", "push after space", 32'(pushValid), 32'b100);
    chk("R5", "data after space", pushData[2], 32'hF00D_0003);
    chk("R5", "stall released", 32'(coreStall), 0);
    @(negedge clk); idle();
  endtask

  task automatic tContention();
    @(negedge clk); idle();
    put(0, W1, 32'hC0C0_0001);
    put(2, W0, 32'hB0B0_0002);
    #1;
    chk("R6", "winner push", 32'(pushValid), 32'b010);
    chk("R6", "winner data", pushData[1], 32'hC0C0_0001);
    chk("R6", "stall loser only", 32'(coreStall), 32'(1) << 2);
    @(negedge clk);
    storeValid[0] = 1'b0;
    #1;
    chk("R6", "loser data next", pushData[1], 32'hB0B0_0002);
    chk("R6", "loser released", 32'(coreStall), 0);
    @(negedge clk); idle();
  endtask

  task automatic tOneShot();
    int pushes = 0;
    @(negedge clk); idle();
    put(1, W0, 32'h0000_0777);
    for (int i = 0; i < 4; i++) begin
      #1;
      pushes += $countones(pushValid);
      @(negedge clk);
      idle();
    end
    chk("R8", "pushes for one store", 32'(pushes), 1);
  endtask

  task automatic tHang();
    @(negedge clk); idle();
    put(2, W2, 32'hBAD0_0002);
    #1;
    chk("R3", "no push on hang", 32'(pushValid), 0);
    chk("R3", "stall same cycle", 32'(coreStall), 32'(1) << 2);
    @(negedge clk); idle(); #1;
    chk("R3", "flag set", 32'(hangErr), 32'(1) << 2);
    chk("R3", "stall held", 32'(coreStall), 32'(1) << 2);
    @(negedge clk);
    put(2, W0, 32'h0000_0011);
    put(1, W0, 32'h0000_0022);
    #1;
    chk("R3", "hung core no push", 32'(pushValid), 32'b001);
    chk("R3", "others unaffected", pushData[0], 32'h0000_0022);
    repeat (3) @(negedge clk);
    idle(); #1;
    chk("R3", "still hung", 32'(hangErr), 32'(1) << 2);
    doReset();
    @(negedge clk); #1;
    chk("R3", "cleared by reset", 32'(hangErr), 0);
    chk("R3", "stall cleared by reset", 32'(coreStall), 0);
    put(2, W0, 32'h0000_0033);
    #1;
    chk("R3", "push after reset", pushData[1], 32'h0000_0033);
    @(negedge clk); idle();
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    #1;
    chk("R9", "push in reset", 32'(pushValid), 0);
    doReset();
    tReset();
    tCtrlRoute();
    tThreadRoute();
    tNetwork();
    tOffWindow();
    tFull();
    tContention();
    tOneShot();
    tHang();
    finishRun();
  end
endmodule